// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits each and returns the full `2*WIDTH`-bit signed product. `WIDTH` must be even. The block works through the multiplier two bits per clock. Each step looks at three adjacent multiplier bits: the two new bits and the upper bit of the previous pair. For the lowest pair, a zero stands in below bit 0. From these three bits the step chooses one multiple of the multiplicand: zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. The step adds that multiple into a running accumulator. The accumulator and the remaining multiplier bits then shift right arithmetically by two places. A full product therefore takes `WIDTH/2` steps, which is half the count of a one-bit-per-step shift-and-add design.

To use the block, the host presents both operands and raises `start` for one cycle while `busy` is low. `busy` then stays high for the duration of the steps. In the first cycle after `busy` falls, `done` pulses and `product` carries the result. `product` then holds that result until the next operation is accepted.

Top module: `booth4_mult`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the next cycle shows `busy` = 0, `done` = 0 and `product` = 0.
- R2: `start` is taken only while `busy` is low. A `start` raised while `busy` is high has no effect: the running result, its timing and the following idle period are unchanged.
- R3: After an accepted `start`, `busy` is high for exactly `WIDTH/2` cycles. `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R4: When `done` is high, `product` equals the signed product of the operands captured at the accepted `start`, for every operand pair.
- R5: Each step recodes the multiplier bit group (b[2i+1], b[2i], b[2i-1]), with b[-1] = 0, as follows: 000 and 111 add zero; 001 and 010 add +X; 011 adds +2X; 100 adds -2X; 101 and 110 add -X. Here X is the sign-extended multiplicand. A step adds at most one multiple.
- R6: With `WIDTH` = 6, multiplicand 25 and multiplier -18 give product -450 (12-bit value 0xE3E).
- R7: The most negative multiplicand times the most negative multiplier gives the positive value 2^(2*WIDTH-2).
- R8: While `busy` is low and no `start` is taken, `product` stays unchanged, even when the operand inputs change.
- R9: A `start` in the same cycle as `done` is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiply; taken only when idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | High while recoding steps are running |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
The hardest case to reach is a step that adds +2X or -2X while the multiplicand is at its most negative value. This is the point where the accumulator must hold a magnitude of 2^WIDTH without wrapping, and only a handful of operand pairs reach it. At `WIDTH` = 6, the stimulus sweeps every one of the 4096 operand pairs, so each group code meets each extreme multiplicand. A separate directed case covers the pairing of the two most negative operands. A second instance at `WIDTH` = 16 runs random pairs plus these extremes. Dedicated tasks also raise `start` part way through an operation, and again in the same cycle as `done`.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  typedef enum logic [2:0] {
    MUL_ZERO = 3'd0,
    MUL_PX   = 3'd1,
    MUL_P2X  = 3'd2,
    MUL_NX   = 3'd3,
    MUL_N2X  = 3'd4
  } mult_sel_e;

  // Map a three-bit multiplier window (high, mid, low) to a multiple.
  function automatic mult_sel_e recode_group(input logic [2:0] grp);
    mult_sel_e r;
    unique case (grp)
      3'b001, 3'b010: r = MUL_PX;
      3'b011:         r = MUL_P2X;
      3'b100:         r = MUL_N2X;
      3'b101, 3'b110: r = MUL_NX;
      default:        r = MUL_ZERO;
    endcase
    return r;
  endfunction

  function automatic logic sel_negative(input mult_sel_e s);
    return (s == MUL_NX) || (s == MUL_N2X);
  endfunction

  function automatic logic sel_double(input mult_sel_e s);
    return (s == MUL_P2X) || (s == MUL_N2X);
  endfunction

  function automatic logic sel_nonzero(input mult_sel_e s);
    return s != MUL_ZERO;
  endfunction

endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
  import booth4_pkg::*;
(
  input  logic [2:0] grp,
  output mult_sel_e  sel,
  output logic       sel_neg,
  output logic       sel_dbl,
  output logic       sel_nz
);

  always_comb begin
    sel     = recode_group(grp);
    sel_neg = sel_negative(sel);
    sel_dbl = sel_double(sel);
    sel_nz  = sel_nonzero(sel);
  end

endmodule

// File: rtl/booth4_addend.sv
module booth4_addend #(
  parameter int WIDTH = 16,
  localparam int AW = WIDTH + 2
) (
  input  logic [WIDTH-1:0] x,
  input  logic             sel_neg,
  input  logic             sel_dbl,
  input  logic             sel_nz,
  output logic [AW-1:0]    addend,
  output logic             cin
);

  logic [AW-1:0] x_ext;
  logic [AW-1:0] mag;

  always_comb begin
    x_ext = {{2{x[WIDTH-1]}}, x};
    mag   = sel_dbl ? {x_ext[AW-2:0], 1'b0} : x_ext;
    if (!sel_nz) begin
      addend = '0;
      cin    = 1'b0;
    end else if (sel_neg) begin
      addend = ~mag;
      cin    = 1'b1;
    end else begin
      addend = mag;
      cin    = 1'b0;
    end
  end

endmodule

// File: rtl/booth4_seq_ctrl.sv
module booth4_seq_ctrl #(
  parameter int STEPS = 8,
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic step_en,
  output logic last_step,
  output logic busy,
  output logic done
);

  logic [CW-1:0] cnt_q;

  assign accept    = start && !busy;
  assign step_en   = busy;
  assign last_step = busy && (cnt_q == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= last_step;
      if (accept) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (last_step) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else if (busy) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/booth4_mult.sv
module booth4_mult
  import booth4_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int STEPS = WIDTH / 2,
  localparam int AW = WIDTH + 2,
  localparam int PW = 2 * WIDTH,
  localparam int CW = AW + WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  output logic             busy,
  output logic             done,
  output logic [PW-1:0]    product
);

  logic [WIDTH-1:0] x_q;
  logic [AW-1:0]    acc_q;
  logic [WIDTH-1:0] mq_q;
  logic             qm1_q;

  logic             accept;
  logic             step_en;
  logic             last_step;
  logic [2:0]       grp;
  mult_sel_e        sel;
  logic             sel_neg;
  logic             sel_dbl;
  logic             sel_nz;
  logic [AW-1:0]    addend;
  logic             cin;
  logic [AW-1:0]    sum;
  logic [CW-1:0]    joined;
  logic [CW-1:0]    shifted;

  booth4_seq_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .accept    (accept),
    .step_en   (step_en),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  assign grp = {mq_q[1], mq_q[0], qm1_q};

  booth4_recoder u_rec (
    .grp     (grp),
    .sel     (sel),
    .sel_neg (sel_neg),
    .sel_dbl (sel_dbl),
    .sel_nz  (sel_nz)
  );

  booth4_addend #(.WIDTH(WIDTH)) u_add (
    .x       (x_q),
    .sel_neg (sel_neg),
    .sel_dbl (sel_dbl),
    .sel_nz  (sel_nz),
    .addend  (addend),
    .cin     (cin)
  );

  always_comb begin
    sum     = acc_q + addend + AW'(cin);
    joined  = {sum, mq_q, qm1_q};
    shifted = CW'($signed(joined) >>> 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0;
      acc_q <= '0;
      mq_q  <= '0;
      qm1_q <= 1'b0;
    end else if (accept) begin
      x_q   <= mcand;
      acc_q <= '0;
      mq_q  <= mplier;
      qm1_q <= 1'b0;
    end else if (step_en) begin
      acc_q <= shifted[CW-1 -: AW];
      mq_q  <= shifted[WIDTH:1];
      qm1_q <= shifted[0];
    end
  end

  assign product = {acc_q[WIDTH-1:0], mq_q};

endmodule

// File: rtl/booth4_mult_chk.sv
module booth4_mult_chk #(
  parameter int WIDTH = 16,
  localparam int STEPS = WIDTH / 2,
  localparam int BW = $clog2(STEPS + 2) + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [2*WIDTH-1:0]   product,
  input logic                 step_en,
  input logic                 sel_neg,
  input logic                 sel_dbl,
  input logic                 sel_nz
);

  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!busy && !done && product == '0));

  p_busy_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_busy_span_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == BW'(STEPS)));

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_one_multiple_r5: assert property (@(posedge clk) disable iff (rst)
    step_en |-> (!(sel_neg || sel_dbl) || sel_nz));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product));

endmodule

bind booth4_mult booth4_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product),
  .step_en (step_en),
  .sel_neg (sel_neg),
  .sel_dbl (sel_dbl),
  .sel_nz  (sel_nz)
);

// File: tb/sim_booth4_mult.sv
module sim_booth4_mult;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 6;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;

  logic          st_a = 1'b0;
  logic [NA-1:0] xa = '0, ya = '0;
  logic          busy_a, done_a;
  logic [2*NA-1:0] prod_a;

  logic          st_b = 1'b0;
  logic [NB-1:0] xb = '0, yb = '0;
  logic          busy_b, done_b;
  logic [2*NB-1:0] prod_b;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth4_mult #(.WIDTH(NA)) u0 (
    .clk(clk), .rst(rst), .start(st_a), .mcand(xa), .mplier(ya),
    .busy(busy_a), .done(done_a), .product(prod_a));

  booth4_mult #(.WIDTH(NB)) u1 (
    .clk(clk), .rst(rst), .start(st_b), .mcand(xb), .mplier(yb),
    .busy(busy_b), .done(done_b), .product(prod_b));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*NA-1:0] ref_a(input logic [NA-1:0] a, input logic [NA-1:0] b);
    logic signed [2*NA-1:0] r;
    r = $signed({{NA{a[NA-1]}}, a}) * $signed({{NA{b[NA-1]}}, b});
    return r;
  endfunction

  function automatic logic [2*NB-1:0] ref_b(input logic [NB-1:0] a, input logic [NB-1:0] b);
    logic signed [2*NB-1:0] r;
    r = $signed({{NB{a[NB-1]}}, a}) * $signed({{NB{b[NB-1]}}, b});
    return r;
  endfunction

  // One full operation on the 6-bit instance; returns busy length and done flag.
  task automatic op_a(input logic [NA-1:0] a, input logic [NA-1:0] b,
                      output int blen, output logic dn, output logic [2*NA-1:0] p);
    @(negedge clk);
    xa = a; ya = b; st_a = 1'b1;
    @(negedge clk);
    st_a = 1'b0;
    blen = 0;
    while (busy_a) begin blen++; @(negedge clk); end
    dn = done_a;
    p  = prod_a;
  endtask

  task automatic op_b(input logic [NB-1:0] a, input logic [NB-1:0] b, input string req);
    int blen;
    @(negedge clk);
    xb = a; yb = b; st_b = 1'b1;
    @(negedge clk);
    st_b = 1'b0;
    blen = 0;
    while (busy_b) begin blen++; @(negedge clk); end
    check({req, " busy length 16-bit"}, 64'(blen), 64'(NB/2));
    check({req, " product 16-bit"}, 64'(prod_b), 64'(ref_b(a, b)));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 busy", 64'(busy_a), 64'd0);
    check("R1 done", 64'(done_a), 64'd0);
    check("R1 product", 64'(prod_a), 64'd0);
    check("R1 product 16-bit", 64'(prod_b), 64'd0);
  endtask

  task automatic t_example;
    int bl; logic dn; logic [2*NA-1:0] p;
    op_a(6'd25, 6'b101110, bl, dn, p);
    check("R6 example product", 64'(p), 64'hE3E);
    check("R3 busy length", 64'(bl), 64'(NA/2));
    check("R3 done at end", 64'(dn), 64'd1);
    @(negedge clk);
    check("R3 done single", 64'(done_a), 64'd0);
  endtask

  task automatic t_extremes;
    int bl; logic dn; logic [2*NA-1:0] p;
    op_a(6'b100000, 6'b100000, bl, dn, p);
    check("R7 min x min 6-bit", 64'(p), 64'(1) << (2*NA-2));
    op_b(16'h8000, 16'h8000, "R7");
    check("R7 min x min 16-bit", 64'(prod_b), 64'(1) << (2*NB-2));
    op_a(6'b100000, 6'b011111, bl, dn, p);
    check("R7 min x max", 64'(p), 64'(ref_a(6'b100000, 6'b011111)));
  endtask

  task automatic t_exhaustive;
    int bl; logic dn; logic [2*NA-1:0] p;
    int bad_before;
    bad_before = n_bad;
    for (int i = 0; i < (1 << NA); i++) begin
      for (int j = 0; j < (1 << NA); j++) begin
        op_a(NA'(i), NA'(j), bl, dn, p);
        // R4 and R5: every group code meets every multiplicand
        check("R4/R5 exhaustive product", 64'(p), 64'(ref_a(NA'(i), NA'(j))));
        if (bl != NA/2 || !dn) check("R3 timing exhaustive", 64'(bl), 64'(NA/2));
      end
    end
    if (n_bad != bad_before) $display("exhaustive sweep had mismatches");
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++) op_b(NB'($urandom), NB'($urandom), "R4 random");
    op_b(16'h7FFF, 16'h8000, "R4 max x min");
    op_b(16'hFFFF, 16'h8000, "R4 -1 x min");
  endtask

  task automatic t_start_busy;
    int bl;
    @(negedge clk);
    xa = 6'd13; ya = 6'b110011; st_a = 1'b1;
    @(negedge clk);
    st_a = 1'b0;
    bl = 0;
    while (busy_a) begin
      bl++;
      if (bl == 1) begin xa = 6'd31; ya = 6'd31; st_a = 1'b1; end
      else st_a = 1'b0;
      @(negedge clk);
    end
    st_a = 1'b0;
    check("R2 busy length with stray start", 64'(bl), 64'(NA/2));
    check("R2 product unaffected", 64'(prod_a), 64'(ref_a(6'd13, 6'b110011)));
    @(negedge clk);
    check("R2 no restart", 64'(busy_a), 64'd0);
  endtask

  task automatic t_hold;
    logic [2*NA-1:0] keep;
    int bl; logic dn; logic [2*NA-1:0] p;
    op_a(6'b111011, 6'd21, bl, dn, p);
    keep = prod_a;
    for (int k = 0; k < 5; k++) begin
      xa = NA'(k * 7); ya = NA'(k * 11);
      @(negedge clk);
    end
    check("R8 product held", 64'(prod_a), 64'(keep));
    check("R8 done low", 64'(done_a), 64'd0);
  endtask

  task automatic t_back_to_back;
    int bl; logic dn; logic [2*NA-1:0] p;
    op_a(6'd9, 6'd7, bl, dn, p);
    st_a = 1'b1; xa = 6'b101010; ya = 6'd17;
    @(negedge clk);
    st_a = 1'b0;
    check("R9 accepted on done cycle", 64'(busy_a), 64'd1);
    bl = 0;
    while (busy_a) begin bl++; @(negedge clk); end
    check("R9 second product", 64'(prod_a), 64'(ref_a(6'b101010, 6'd17)));
    check("R9 second busy length", 64'(bl), 64'(NA/2));
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_example();
    t_extremes();
    t_start_busy();
    t_hold();
    t_back_to_back();
    t_random();
    t_exhaustive();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule